// File: doc/BRIEF.md
# Shared-Bus Data-Phase Beat Tracker with Hang Watchdog

This block sits beside a 64-bit shared processor bus and follows the data phase of each transfer. A start strobe opens a transfer and says whether it is a single beat or a four-beat burst. Each cycle with transfer acknowledge high counts one valid data beat. The block emits a one-cycle end-of-transfer pulse when the last beat arrives.

Every byte lane of the data bus has its own odd-parity line. The block computes the parity value to drive when it owns the bus. It checks incoming parity on acknowledged beats that another agent drives.

A watchdog opens with each transfer and restarts on every beat. If the transfer stalls for the programmed number of cycles, the block raises transfer-error acknowledge for one cycle and drops the transfer. An error acknowledge from another agent also drops the transfer at once. A start strobe that arrives while a transfer is still open is ignored and recorded in a sticky flag.

Top module: `bus_beat_monitor`

## Requirements
- R1: After rst_n has been low at a clock edge, busy_o, done_o, tea_o, par_err_o and proto_err_o are all 0.
- R2: When start_i is sampled while idle with burst_i=0, busy_o goes high. The next sampled ack_i=1 ends the transfer: in the following cycle done_o is 1 for exactly one cycle and busy_o is 0.
- R3: When start_i is sampled while idle with burst_i=1, the transfer needs four sampled ack_i beats, which need not be consecutive. done_o stays 0 after the first three and pulses for one cycle after the fourth.
- R4: par_o[n] is chosen so that par_o[n] together with data_i[8n+7:8n] holds an odd number of ones. This is combinational.
- R5: After a clock edge with ack_i=1 and drive_i=0, par_err_o[n] is 1 for one cycle exactly when par_i[n] together with data_i[8n+7:8n] holds an even number of ones. In every other case par_err_o is 0. This holds whether or not a transfer is open.
- R6: The watchdog loads tmo_limit_i on an accepted start and on every non-final beat. A limit of 0 acts as 1. After L consecutive sampled edges with no ack_i while busy, tea_o is 1 for exactly one cycle, busy_o drops and done_o stays 0.
- R7: An ack_i sampled on the same edge on which the watchdog would expire counts as a beat. No tea_o is produced, and for a non-final beat the watchdog reloads.
- R8: tea_i sampled while busy ends the transfer with no done_o and no tea_o, and it beats an ack_i on the same edge. The next burst again needs four fresh beats.
- R9: start_i sampled while busy does not change the open transfer or its beat count. It sets proto_err_o, which stays 1 until reset.
- R10: ack_i sampled while idle never produces done_o and does not open a transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Transfer-start strobe |
| burst_i | input | 1 | With start_i: 1 = four-beat burst, 0 = single beat |
| ack_i | input | 1 | Transfer acknowledge, one per valid data beat |
| tea_i | input | 1 | Transfer-error acknowledge driven by another agent |
| drive_i | input | 1 | 1 when this side drives the data bus this beat |
| data_i | input | DATA_W | Data bus |
| par_i | input | DATA_W/8 | Incoming byte-lane parity lines |
| tmo_limit_i | input | TMO_W | Watchdog limit in cycles without a beat |
| par_o | output | DATA_W/8 | Generated odd parity per byte lane |
| done_o | output | 1 | End-of-transfer pulse |
| tea_o | output | 1 | Transfer-error acknowledge from the watchdog |
| par_err_o | output | DATA_W/8 | Per-lane parity error, one cycle |
| busy_o | output | 1 | A transfer is open |
| proto_err_o | output | 1 | Sticky: start seen while busy |

## Verification
The main collision is a final or non-final beat that arrives on the very edge where the watchdog runs out. The bench sweeps limits 0 to 7 and places the acknowledge exactly L cycles after the load. A correct design must then show a done pulse or continued busy with no error acknowledge, and the following timeout must fall exactly L cycles after that beat. The second collision is an outside error acknowledge together with a beat on one edge. The rule judged there is that the abort wins: no done pulse follows, and a fresh burst must count four beats again.

// File: rtl/bbm_pkg.sv
package bbm_pkg;

    localparam int BEATS_PER_BURST = 4;
    localparam int BEAT_W          = $clog2(BEATS_PER_BURST);

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_DATA = 1'b1
    } phase_e;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef struct packed {
        phase_e phase;
        logic   burst;
        beat_t  beats;
        logic   done;
        logic   tea;
        logic   proto;
    } ctrl_t;

endpackage

// File: rtl/bbm_lane_parity.sv
module bbm_lane_parity (
    input  logic [7:0] byte_i,
    input  logic       par_i,
    output logic       gen_o,
    output logic       bad_o
);

    // Odd parity: the generated bit makes the count of ones odd.
    always_comb begin
        gen_o = ~(^byte_i);
        bad_o = ~(^{par_i, byte_i});
    end

endmodule

// File: rtl/bbm_watchdog.sv
module bbm_watchdog #(
    parameter int TMO_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);

    localparam logic [TMO_W-1:0] ONE = TMO_W'(1);

    logic [TMO_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = limit_i;
        end else if (run_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - ONE;
        end
        // A loaded value of 0 or 1 means the next idle edge expires.
        expired_o = (cnt_q <= ONE);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/bus_beat_monitor.sv
module bus_beat_monitor #(
    parameter int DATA_W = 64,
    parameter int TMO_W  = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  burst_i,
    input  logic                  ack_i,
    input  logic                  tea_i,
    input  logic                  drive_i,
    input  logic [DATA_W-1:0]     data_i,
    input  logic [DATA_W/8-1:0]   par_i,
    input  logic [TMO_W-1:0]      tmo_limit_i,
    output logic [DATA_W/8-1:0]   par_o,
    output logic                  done_o,
    output logic                  tea_o,
    output logic [DATA_W/8-1:0]   par_err_o,
    output logic                  busy_o,
    output logic                  proto_err_o
);

    import bbm_pkg::*;

    localparam int    LANES     = DATA_W / 8;
    localparam beat_t LAST_BEAT = beat_t'(BEATS_PER_BURST - 1);

    ctrl_t            cur_q, nxt_d;
    logic [LANES-1:0] perr_d, perr_q;
    logic [LANES-1:0] lane_bad;
    logic             wd_load;
    logic             wd_expired;
    logic             last_beat;

    // One parity slice per byte lane.
    for (genvar n = 0; n < LANES; n++) begin : g_lane
        bbm_lane_parity u_par (
            .byte_i (data_i[8*n +: 8]),
            .par_i  (par_i[n]),
            .gen_o  (par_o[n]),
            .bad_o  (lane_bad[n])
        );
    end

    bbm_watchdog #(.TMO_W(TMO_W)) u_wd (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (wd_load),
        .run_i     (cur_q.phase == PH_DATA),
        .limit_i   (tmo_limit_i),
        .expired_o (wd_expired)
    );

    always_comb begin
        nxt_d      = cur_q;
        nxt_d.done = 1'b0;
        nxt_d.tea  = 1'b0;
        wd_load    = 1'b0;
        last_beat  = !cur_q.burst || (cur_q.beats == LAST_BEAT);

        perr_d = (ack_i && !drive_i) ? lane_bad : '0;

        if (cur_q.phase == PH_IDLE) begin
            if (start_i) begin
                nxt_d.phase = PH_DATA;
                nxt_d.burst = burst_i;
                nxt_d.beats = '0;
                wd_load     = 1'b1;
            end
        end else begin
            if (start_i) begin
                nxt_d.proto = 1'b1;
            end
            if (tea_i) begin
                // Abort from another agent beats any beat this cycle.
                nxt_d.phase = PH_IDLE;
                nxt_d.beats = '0;
            end else if (ack_i) begin
                if (last_beat) begin
                    nxt_d.phase = PH_IDLE;
                    nxt_d.beats = '0;
                    nxt_d.done  = 1'b1;
                end else begin
                    nxt_d.beats = cur_q.beats + beat_t'(1);
                    wd_load     = 1'b1;
                end
            end else if (wd_expired) begin
                nxt_d.phase = PH_IDLE;
                nxt_d.beats = '0;
                nxt_d.tea   = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q  <= '{phase: PH_IDLE, burst: 1'b0, beats: '0,
                        done: 1'b0, tea: 1'b0, proto: 1'b0};
            perr_q <= '0;
        end else begin
            cur_q  <= nxt_d;
            perr_q <= perr_d;
        end
    end

    always_comb begin
        done_o      = cur_q.done;
        tea_o       = cur_q.tea;
        par_err_o   = perr_q;
        busy_o      = (cur_q.phase == PH_DATA);
        proto_err_o = cur_q.proto;
    end

endmodule

// File: rtl/bbm_checker.sv
module bbm_checker #(
    parameter int LANES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             ack_i,
    input logic             tea_i,
    input logic             drive_i,
    input logic             done_o,
    input logic             tea_o,
    input logic [LANES-1:0] par_err_o,
    input logic             busy_o,
    input logic             proto_err_o
);

    AST_START_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> busy_o);                                  // R2
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);                                               // R2
    AST_DONE_CLOSES: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);                                               // R3
    AST_TEA_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        tea_o |=> !tea_o);                                                 // R6
    AST_TEA_NOT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(tea_o && done_o));                                               // R6
    AST_EXT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && tea_i) |=> (!busy_o && !done_o && !tea_o));             // R8
    AST_PERR_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ack_i || drive_i) |=> (par_err_o == '0));                        // R5
    AST_PROTO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> proto_err_o);                              // R9
    AST_PROTO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        proto_err_o |=> proto_err_o);                                      // R9
    AST_IDLE_ACK: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !start_i) |=> (!busy_o && !done_o));                   // R10

endmodule

bind bus_beat_monitor bbm_checker #(.LANES(DATA_W / 8)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .ack_i       (ack_i),
    .tea_i       (tea_i),
    .drive_i     (drive_i),
    .done_o      (done_o),
    .tea_o       (tea_o),
    .par_err_o   (par_err_o),
    .busy_o      (busy_o),
    .proto_err_o (proto_err_o)
);

// File: tb/bus_beat_monitor_test.sv
`timescale 1ns/1ps
module bus_beat_monitor_test;

    localparam int DATA_W = 64;
    localparam int TMO_W  = 4;
    localparam int LANES  = DATA_W / 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_i = 1'b0, burst_i = 1'b0, ack_i = 1'b0;
    logic              tea_i = 1'b0, drive_i = 1'b0;
    logic [DATA_W-1:0] data_i = '0;
    logic [LANES-1:0]  par_i = '0;
    logic [TMO_W-1:0]  tmo_limit_i = TMO_W'(3);
    logic [LANES-1:0]  par_o, par_err_o;
    logic              done_o, tea_o, busy_o, proto_err_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    bus_beat_monitor #(.DATA_W(DATA_W), .TMO_W(TMO_W)) uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .burst_i(burst_i),
        .ack_i(ack_i), .tea_i(tea_i), .drive_i(drive_i), .data_i(data_i),
        .par_i(par_i), .tmo_limit_i(tmo_limit_i), .par_o(par_o),
        .done_o(done_o), .tea_o(tea_o), .par_err_o(par_err_o),
        .busy_o(busy_o), .proto_err_o(proto_err_o)
    );

    always #4 clk = ~clk;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic idle_in();
        start_i = 1'b0; ack_i = 1'b0; tea_i = 1'b0; drive_i = 1'b0;
    endtask

    task automatic open_xfer(input logic burst);
        idle_in();
        start_i = 1'b1; burst_i = burst;
        step();
        start_i = 1'b0;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 1'b0;
        step(); step();
        rst_n = 1'b1;
    endtask

    // Watchdog: an expired run is a failed check and still ends with the summary.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d expected <150000 cycles", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] b;
        int lim;

        do_reset();
        // R1 reset state
        chk("R1 busy", busy_o, 0); chk("R1 done", done_o, 0); chk("R1 tea", tea_o, 0);
        chk("R1 perr", par_err_o, 0); chk("R1 proto", proto_err_o, 0);

        // R4 and R5: sweep byte values over all lanes
        for (int v = 0; v < 256; v++) begin
            logic [LANES-1:0] exp_gen, exp_err;
            idle_in();
            for (int n = 0; n < LANES; n++) begin
                b = 8'(v) ^ 8'(n * 37);
                data_i[8*n +: 8] = b;
                par_i[n] = 1'((v >> n) & 1);
                exp_gen[n] = ($countones(b) % 2 == 0);
                exp_err[n] = (($countones(b) + par_i[n]) % 2 == 0);
            end
            ack_i = 1'b1;
            drive_i = 1'((v % 3) == 0);
            #1;
            chk("R4 par_o", par_o, exp_gen);
            step();
            chk("R5 par_err", par_err_o, drive_i ? '0 : exp_err);
            chk("R10 idle ack", {busy_o, done_o}, 0);
        end
        idle_in();
        step();
        chk("R5 quiet", par_err_o, 0);

        // R2 single beat, varied gap before the beat
        tmo_limit_i = TMO_W'(9);
        for (int g = 0; g < 4; g++) begin
            open_xfer(1'b0);
            chk("R2 busy", busy_o, 1);
            for (int k = 0; k < g; k++) step();
            ack_i = 1'b1; step(); ack_i = 1'b0;
            chk("R2 done", done_o, 1); chk("R2 closed", busy_o, 0);
            step();
            chk("R2 pulse", done_o, 0);
        end

        // R3 burst with gap patterns
        for (int p = 0; p < 8; p++) begin
            open_xfer(1'b1);
            for (int beat = 0; beat < 4; beat++) begin
                for (int k = 0; k < ((p >> (beat % 3)) & 1); k++) step();
                ack_i = 1'b1; step(); ack_i = 1'b0;
                chk("R3 done", done_o, beat == 3);
                chk("R3 busy", busy_o, beat != 3);
            end
            step();
            chk("R3 pulse", done_o, 0);
        end

        // R6 timeout sweep over limits, and R7 beat on expiry edge
        for (lim = 0; lim < 8; lim++) begin
            int eff;
            eff = (lim == 0) ? 1 : lim;
            tmo_limit_i = TMO_W'(lim);
            open_xfer(1'b0);
            for (int k = 1; k <= eff; k++) begin
                step();
                chk("R6 tea", tea_o, k == eff);
                chk("R6 busy", busy_o, k != eff);
                chk("R6 nodone", done_o, 0);
            end
            step();
            chk("R6 tea pulse", tea_o, 0);

            open_xfer(1'b1);
            for (int k = 1; k < eff; k++) step();
            ack_i = 1'b1; step(); ack_i = 1'b0;
            chk("R7 no tea", tea_o, 0); chk("R7 busy", busy_o, 1);
            for (int k = 1; k <= eff; k++) begin
                step();
                chk("R7 reload tea", tea_o, k == eff);
            end
            open_xfer(1'b0);
            for (int k = 1; k < eff; k++) step();
            ack_i = 1'b1; step(); ack_i = 1'b0;
            chk("R7 final done", done_o, 1); chk("R7 final tea", tea_o, 0);
        end

        // R8 external abort mid-burst and with a beat on the same edge
        tmo_limit_i = TMO_W'(15);
        open_xfer(1'b1);
        ack_i = 1'b1; step(); step(); ack_i = 1'b0;
        tea_i = 1'b1; step(); tea_i = 1'b0;
        chk("R8 closed", busy_o, 0); chk("R8 nodone", done_o, 0); chk("R8 notea", tea_o, 0);
        open_xfer(1'b1);
        for (int beat = 0; beat < 4; beat++) begin
            ack_i = 1'b1; step(); ack_i = 1'b0;
            chk("R8 fresh count", done_o, beat == 3);
        end
        open_xfer(1'b0);
        ack_i = 1'b1; tea_i = 1'b1; step(); idle_in();
        chk("R8 tea wins", {busy_o, done_o}, 0);

        // R9 start while busy is ignored and sticky
        open_xfer(1'b1);
        ack_i = 1'b1; step(); ack_i = 1'b0;
        start_i = 1'b1; burst_i = 1'b0; step(); start_i = 1'b0;
        chk("R9 proto", proto_err_o, 1);
        ack_i = 1'b1; step();
        chk("R9 not restarted", done_o, 0);
        step(); chk("R9 beat3", done_o, 0);
        step(); ack_i = 1'b0;
        chk("R9 fourth", done_o, 1);
        step(); step();
        chk("R9 sticky", proto_err_o, 1);
        do_reset();
        chk("R1 proto cleared", proto_err_o, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule